// File: doc/BRIEF.md
# Time-Match Alarm Interrupt Unit

This unit sits beside a real-time clock's counter chain and watches the running seconds, minutes and hours. It holds three alarm latches, one for each of those fields. When all three latches equal the current time, it records an alarm event in a status register. If the alarm is enabled, it also pulls an active-low interrupt line. The time counters and the serial host link are outside the unit. It sees the counter values as BCD bytes, a one-cycle tick strobe that marks each counter update, and a simple register port with write, read, address and data.

The comparison is made once per tick, in the cycle that follows the tick, so a matching second produces exactly one event. The status flag records every match, whether or not the alarm is enabled. The enable bit only gates the interrupt pin. Software clears the enable bit while it rewrites the time counters, which keeps the pin quiet during that rewrite. Reading the status register clears the flag and releases the pin.

Top module: `tm_alarm_unit`

## Requirements
- R1: After reset, all three alarm latches read 0x00, the control register reads 0x00, the status register reads 0x00 and `irq_n` is high.
- R2: Register map on `reg_addr`: 0 is the seconds latch, 1 is the minutes latch and 2 is the hours latch, each a full 8 bits. Address 3 is control, with the alarm enable in bit 0 and the other bits reading 0. Address 4 is status, with the alarm flag in bit 0 and the other bits reading 0. Writes take effect on the clock edge where `reg_wr` is high, and every latch and the control register hold their value otherwise.
- R3: In the cycle after a `tick` cycle, if seconds, minutes and hours all equal their latches, the alarm flag is set at the end of that cycle.
- R4: If any single field differs from its latch, no event occurs on that tick.
- R5: No event occurs without a tick. Equal values held across cycles with no `tick` leave the flag unchanged.
- R6: `irq_n` is low exactly when the alarm flag is set and the enable bit is 1. With the enable bit clear, a match still sets the flag but `irq_n` stays high.
- R7: A read of address 4 returns the flag in bit 0 and clears the flag at the end of that read cycle, which releases `irq_n`.
- R8: If a match event and a status read fall in the same cycle, the read returns the old flag value and the flag is left set.
- R9: A write to address 4 has no effect on the flag.
- R10: The hours comparison covers all 8 bits, including the 12/24-hour mode bit 7 and the AM/PM bit 5. Hours 0x12 therefore do not match a latch value of 0x92.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe: the counters changed this cycle |
| cur_sec | input | 8 | Seconds counter, BCD |
| cur_min | input | 8 | Minutes counter, BCD |
| cur_hr | input | 8 | Hours counter, BCD with mode and AM/PM bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The assertions check several rules on every cycle:
- a compare hit always sets the flag, and the flag never rises without a hit;
- the pin follows the flag and the enable bit together;
- a status read clears the flag unless a hit lands in the same cycle;
- the latches and the control bit change only on writes.

Other behaviours can only be shown by the bench's scenarios, because they depend on stimulus:
- the exact register encoding and read-back values;
- the rejection of partial matches and of a full-byte hours mismatch;
- the absence of events when equal values are held with no tick;
- the read that wins no race against a simultaneous hit.

// File: rtl/tm_alarm_pkg.sv
package tm_alarm_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_SEC  = 3'd0;
  localparam logic [AW-1:0] ADR_MIN  = 3'd1;
  localparam logic [AW-1:0] ADR_HR   = 3'd2;
  localparam logic [AW-1:0] ADR_CTRL = 3'd3;
  localparam logic [AW-1:0] ADR_STAT = 3'd4;

  // all three fields equal, every bit of each byte compared
  function automatic logic time_equal(
    input logic [DW-1:0] s, input logic [DW-1:0] m, input logic [DW-1:0] h,
    input logic [DW-1:0] as, input logic [DW-1:0] am, input logic [DW-1:0] ah);
    return (s == as) && (m == am) && (h == ah);
  endfunction

  // single flag bit placed in an otherwise zero byte
  function automatic logic [DW-1:0] bit0_byte(input logic b);
    return {{(DW-1){1'b0}}, b};
  endfunction
endpackage

// File: rtl/tm_alarm_regs.sv
module tm_alarm_regs
  import tm_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] al_sec,
  output logic [DW-1:0] al_min,
  output logic [DW-1:0] al_hr,
  output logic          alarm_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_sec   <= '0;
      al_min   <= '0;
      al_hr    <= '0;
      alarm_en <= 1'b0;
    end else if (wr) begin
      case (addr)
        ADR_SEC:  al_sec   <= wdata;
        ADR_MIN:  al_min   <= wdata;
        ADR_HR:   al_hr    <= wdata;
        ADR_CTRL: alarm_en <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tm_alarm_match.sv
module tm_alarm_match
  import tm_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hr,
  input  logic [DW-1:0] al_sec,
  input  logic [DW-1:0] al_min,
  input  logic [DW-1:0] al_hr,
  output logic          hit
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick;
  end

  assign hit = tick_q && time_equal(cur_sec, cur_min, cur_hr, al_sec, al_min, al_hr);
endmodule

// File: rtl/tm_alarm_status.sv
module tm_alarm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  input  logic alarm_en,
  output logic flag,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)       flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assign irq_n = ~(flag & alarm_en);
endmodule

// File: rtl/tm_alarm_unit.sv
module tm_alarm_unit
  import tm_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] cur_sec,
  input  logic [DW-1:0] cur_min,
  input  logic [DW-1:0] cur_hr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_n
);
  logic [DW-1:0] al_sec, al_min, al_hr;
  logic          alarm_en;
  logic          cmp_hit;
  logic          stat_clr;
  logic          alarm_flag;

  assign stat_clr = reg_rd && (reg_addr == ADR_STAT);

  tm_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr), .alarm_en(alarm_en)
  );

  tm_alarm_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr), .hit(cmp_hit)
  );

  tm_alarm_status u_status (
    .clk(clk), .rst_n(rst_n), .hit(cmp_hit), .clr_req(stat_clr),
    .alarm_en(alarm_en), .flag(alarm_flag), .irq_n(irq_n)
  );

  always_comb begin
    case (reg_addr)
      ADR_SEC:  reg_rdata = al_sec;
      ADR_MIN:  reg_rdata = al_min;
      ADR_HR:   reg_rdata = al_hr;
      ADR_CTRL: reg_rdata = bit0_byte(alarm_en);
      ADR_STAT: reg_rdata = bit0_byte(alarm_flag);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tm_alarm_chk.sv
module tm_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hit,
  input logic       clr_req,
  input logic       wr,
  input logic       flag,
  input logic       alarm_en,
  input logic       irq_n,
  input logic [7:0] al_sec,
  input logic [7:0] al_min,
  input logic [7:0] al_hr
);
  AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) hit |=> flag); // R3
  AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(hit)); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) !alarm_en |-> irq_n); // R6
  AST_IRQ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n) (alarm_en && flag) |-> !irq_n); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_req && !hit) |=> !flag); // R7
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_req && hit) |=> flag); // R8
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable({al_sec, al_min, al_hr, alarm_en})); // R2
endmodule

bind tm_alarm_unit tm_alarm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .hit(cmp_hit), .clr_req(stat_clr), .wr(reg_wr),
  .flag(alarm_flag), .alarm_en(alarm_en), .irq_n(irq_n),
  .al_sec(al_sec), .al_min(al_min), .al_hr(al_hr)
);

// File: tb/test_tm_alarm_unit.sv
`timescale 1ns/1ps
module test_tm_alarm_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hr = 0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  tm_alarm_unit i_tm_alarm_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (reg_rd) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %02h expected none", reg_rdata);
      end else begin
        it = sb.pop_front();
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s: irq_n actual %0b expected %0b", tag, irq_n, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    reg_rd = 1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 0;
  endtask

  // tick cycle, then compare cycle; returns after the compare edge
  task automatic do_tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    @(posedge clk); #1;
    cur_sec = s; cur_min = m; cur_hr = h; tick = 1;
    @(posedge clk); #1;
    tick = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    chk_irq(1'b1, "R1 irq_n after reset");
    for (int a = 0; a < 5; a++) do_read(a[2:0], 8'h00, "R1 reset value");

    // R2 register map
    do_write(3'd0, 8'h30);
    do_write(3'd1, 8'h15);
    do_write(3'd2, 8'h92);
    do_write(3'd3, 8'hFF);
    do_read(3'd0, 8'h30, "R2 seconds latch");
    do_read(3'd1, 8'h15, "R2 minutes latch");
    do_read(3'd2, 8'h92, "R2 hours latch");
    do_read(3'd3, 8'h01, "R2 control only bit0");

    // R10 hours mode bit differs
    do_tick(8'h30, 8'h15, 8'h12);
    chk_irq(1'b1, "R10 hours 0x12 vs 0x92");
    do_read(3'd4, 8'h00, "R10 no flag");

    // R4 partial matches
    do_tick(8'h31, 8'h15, 8'h92);
    chk_irq(1'b1, "R4 seconds differ");
    do_tick(8'h30, 8'h16, 8'h92);
    chk_irq(1'b1, "R4 minutes differ");
    do_read(3'd4, 8'h00, "R4 no flag");

    // R5 equal values without tick
    @(posedge clk); #1;
    cur_sec = 8'h30; cur_min = 8'h15; cur_hr = 8'h92;
    repeat (4) @(posedge clk);
    #1 chk_irq(1'b1, "R5 no tick no event");
    do_read(3'd4, 8'h00, "R5 flag stays clear");

    // R3 / R6 / R7 full match with enable
    do_tick(8'h30, 8'h15, 8'h92);
    chk_irq(1'b0, "R3 R6 match drives irq");
    do_read(3'd4, 8'h01, "R7 status shows flag");
    chk_irq(1'b1, "R7 read releases irq");
    do_read(3'd4, 8'h00, "R7 flag cleared");

    // R9 write to status ignored
    do_write(3'd4, 8'hFF);
    chk_irq(1'b1, "R9 status write no irq");
    do_read(3'd4, 8'h00, "R9 status write ignored");

    // R6 masked enable still sets flag
    do_write(3'd3, 8'h00);
    do_tick(8'h30, 8'h15, 8'h92);
    chk_irq(1'b1, "R6 masked irq");
    do_read(3'd4, 8'h01, "R6 flag set while masked");
    do_read(3'd4, 8'h00, "R7 cleared after masked read");

    // R8 hit and status read in the same cycle
    do_write(3'd3, 8'h01);
    begin
      item_t it;
      @(posedge clk); #1;
      tick = 1;
      @(posedge clk); #1;
      tick = 0;
      it.exp = 8'h00; it.tag = "R8 read during hit returns old";
      sb.push_back(it);
      reg_rd = 1; reg_addr = 3'd4;
      @(posedge clk); #1;
      reg_rd = 0;
    end
    chk_irq(1'b0, "R8 flag survives read");
    do_read(3'd4, 8'h01, "R8 flag kept");

    // R5 one tick, one event: held values with no further tick
    repeat (5) @(posedge clk);
    #1 chk_irq(1'b1, "R5 no repeat event");
    do_read(3'd4, 8'h00, "R5 single event");

    repeat (2) @(posedge clk);
    #1;
    if (sb.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule